// File: doc/BRIEF.md
# Debounced Clock-Lock Qualifier

After a serial lane is reconfigured, its receive clock takes a while to settle onto the shared PLL. During that time the lock indication can toggle at random. This block decides whether the lock has settled. A start strobe begins a qualification run. The block then looks at the lock bit of the selected lane once per fixed interval. It reports success once it sees an unbroken run of good looks. It reports a timeout if the sample budget runs out first.

Two lanes share one PLL, so two lock bits arrive side by side. A parity input, captured together with the start strobe, chooses which bit is examined: the even lane or the odd lane. The results hold until the next start strobe. A start strobe that arrives during a run throws away the progress of that run and begins a new one.

Top module: `lock_settle_judge`

## Requirements
- R1: While reset is asserted and after reset is released, `done_o`, `ok_o` and `timeout_o` are all low.
- R2: The clock edge that sees `start_i` high clears all three result outputs. The first sample is taken WAIT_CYCLES clock edges after that edge, and each later sample follows the previous one by WAIT_CYCLES edges. The lock-bit level between sample edges has no effect on the result.
- R3: `lane_odd_i` is captured at the start edge. A value of 0 selects `lock_rdy_i[0]` (even lane) and a value of 1 selects `lock_rdy_i[1]` (odd lane). The unselected bit has no effect.
- R4: When the selected bit is high on RUN_LEN (default 3) consecutive samples, `done_o` and `ok_o` go high directly after the sample edge that saw the last of those samples.
- R5: A sample with the selected bit low clears the run count, so good samples on either side of a low sample never add together.
- R6: When MAX_SAMPLES (default 20) samples have been taken without a qualifying run, `done_o` and `timeout_o` go high directly after the last sample edge. A run that completes on the last sample still counts as success.
- R7: `ok_o` and `timeout_o` are never high together, and neither is high without `done_o`. Once set, the results hold unchanged until the next start strobe, whatever the lock bits do.
- R8: A start strobe during a run restarts it completely: the sample count, the run count and the sample timer all begin again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin (or restart) a qualification run |
| lane_odd_i | input | 1 | Lane parity, captured at start: 0 even, 1 odd |
| lock_rdy_i | input | 2 | Lock bits: [0] even lane, [1] odd lane |
| done_o | output | 1 | Run finished; held until next start |
| ok_o | output | 1 | Qualifying run found |
| timeout_o | output | 1 | Sample budget exhausted without a qualifying run |

## Verification
The main function is driven with per-sample lock patterns on both lanes. The patterns include an immediate run, a run broken by a single low sample, repeating two-high/one-low groups that never reach three in a row, a run that completes only on the final allowed sample, two good samples at the very end, and all lows. Together these separate correct consecutive counting from cumulative counting and show exactly where the budget boundary lies. In every window the selected bit is held at the opposite level until the cycle just before the sample edge, and the unselected bit is always driven opposite to the selected one. This exposes a sampling instant that is off by even one cycle, as well as a swapped lane select. Directed cases restart the block partway through a run and toggle the lock bits after a result is in, to confirm that the results hold.

// File: rtl/lock_settle_judge.sv
module lock_settle_judge #(
  parameter int WAIT_CYCLES = 8,
  parameter int MAX_SAMPLES = 20,
  parameter int RUN_LEN     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       lane_odd_i,
  input  logic [1:0] lock_rdy_i,
  output logic       done_o,
  output logic       ok_o,
  output logic       timeout_o
);
  localparam int WW = $clog2(WAIT_CYCLES + 1);
  localparam int SW = $clog2(MAX_SAMPLES + 1);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic          busy_q, odd_q, done_q, ok_q, to_q;
  logic [WW-1:0] wait_q;
  logic [SW-1:0] smp_q;
  logic [RW-1:0] run_q;

  logic tick, sel_rdy, hit, last;

  assign tick    = busy_q && (wait_q == '0);
  assign sel_rdy = lock_rdy_i[odd_q];
  assign hit     = sel_rdy && (run_q == RW'(RUN_LEN - 1));
  assign last    = smp_q == SW'(MAX_SAMPLES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      odd_q  <= 1'b0;
      wait_q <= '0;
      smp_q  <= '0;
      run_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      to_q   <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      odd_q  <= lane_odd_i;
      wait_q <= WW'(WAIT_CYCLES - 1);
      smp_q  <= '0;
      run_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      to_q   <= 1'b0;
    end else if (tick) begin
      wait_q <= WW'(WAIT_CYCLES - 1);
      smp_q  <= smp_q + 1'b1;
      run_q  <= sel_rdy ? run_q + 1'b1 : '0;
      if (hit) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        ok_q   <= 1'b1;
      end else if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        to_q   <= 1'b1;
      end
    end else if (busy_q) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign done_o    = done_q;
  assign ok_o      = ok_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/lock_settle_judge_chk.sv
module lock_settle_judge_chk #(
  parameter int SW          = 5,
  parameter int MAX_SAMPLES = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [1:0]    lock_rdy_i,
  input logic          odd_q,
  input logic [SW-1:0] smp_q,
  input logic          done_o,
  input logic          ok_o,
  input logic          timeout_o
);
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && timeout_o));

  assert_need_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o || timeout_o) |-> done_o);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> ($stable(ok_o) && $stable(timeout_o) && done_o));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o && !ok_o && !timeout_o);

  assert_ok_on_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_o) |-> $past(lock_rdy_i[odd_q]));

  assert_timeout_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> ($past(smp_q) == SW'(MAX_SAMPLES - 1)));
endmodule

bind lock_settle_judge lock_settle_judge_chk #(.SW(SW), .MAX_SAMPLES(MAX_SAMPLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .lock_rdy_i(lock_rdy_i),
  .odd_q(odd_q), .smp_q(smp_q),
  .done_o(done_o), .ok_o(ok_o), .timeout_o(timeout_o)
);

// File: tb/lock_settle_judge_tb.sv
module lock_settle_judge_tb_top;
  localparam int W = 8;
  localparam int NMAX = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lane = 1'b0;
  logic [1:0] rdy = 2'b00;
  logic done, ok, tmo;
  int compared = 0, mismatched = 0, cycles = 0;

  always #5 clk = ~clk;

  lock_settle_judge #(.WAIT_CYCLES(W), .MAX_SAMPLES(NMAX), .RUN_LEN(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lane_odd_i(lane),
    .lock_rdy_i(rdy), .done_o(done), .ok_o(ok), .timeout_o(tmo));

  // {lane, pattern (bit k-1 = sample k), expected ok, expected sample index of done}
  localparam logic [26:0] VEC [8] = '{
    {1'b0, 20'h00007, 1'b1, 5'd3},
    {1'b1, 20'h00000, 1'b0, 5'd20},
    {1'b0, 20'h0003B, 1'b1, 5'd6},
    {1'b1, 20'hE0000, 1'b1, 5'd20},
    {1'b0, 20'h36DB6, 1'b0, 5'd20},
    {1'b1, 20'hFFFFF, 1'b1, 5'd3},
    {1'b0, 20'h3C000, 1'b1, 5'd17},
    {1'b1, 20'hC0000, 1'b0, 5'd20}
  };

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(logic ln);
    @(negedge clk); start = 1'b1; lane = ln;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
  endtask

  // one sample window: selected bit held opposite until the last cycle before the sample edge
  task automatic window(logic ln, logic b);
    rdy[ln] = ~b; rdy[~ln] = b;
    repeat (W - 1) @(posedge clk);
    @(negedge clk); rdy[ln] = b; rdy[~ln] = ~b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(logic [26:0] v, int idx);
    logic ln = v[26];
    logic [19:0] pat = v[25:6];
    int seen = 0;
    strobe(ln);
    check($sformatf("R2 clear at start v%0d", idx), done, 0);
    for (int k = 1; k <= NMAX && seen == 0; k++) begin
      window(ln, pat[k-1]);
      if (done) seen = k;
    end
    check($sformatf("R4/R5/R6 done sample v%0d", idx), seen, int'(v[4:0]));
    check($sformatf("R4 ok v%0d", idx), ok, int'(v[5]));
    check($sformatf("R6 timeout v%0d", idx), tmo, int'(!v[5]));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 ok in reset", ok, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 flags after reset", {29'd0, done, ok, tmo}, 0);

    for (int i = 0; i < 8; i++) run_vec(VEC[i], i);

    // R7: results hold while lock bits toggle
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); rdy = 2'(i);
    end
    check("R7 hold done", done, 1);
    check("R7 hold timeout", tmo, 1);
    check("R7 hold ok", ok, 0);

    // R8: restart after two good samples needs three fresh ones
    strobe(1'b0);
    window(1'b0, 1'b1);
    window(1'b0, 1'b1);
    strobe(1'b0);
    window(1'b0, 1'b1);
    check("R8 no done after 1 post-restart", done, 0);
    window(1'b0, 1'b1);
    check("R8 no done after 2 post-restart", done, 0);
    window(1'b0, 1'b1);
    check("R8 done after 3 post-restart", done, 1);
    check("R8 ok after restart", ok, 1);

    // R3: a run on the unselected lane only never qualifies
    strobe(1'b1);
    for (int k = 0; k < 4; k++) begin
      rdy = 2'b01;
      repeat (W) @(posedge clk);
      @(negedge clk);
    end
    check("R3 odd lane ignores even bit", done, 0);
    strobe(1'b0);
    check("R2 start clears flags", {30'd0, ok, tmo}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule